// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the register-side half of an SPI master. A simple single-cycle register bus reaches a small set of control words and two byte-wide FIFOs through fixed data windows. The block holds the global control bits, the interrupt enable and pending-event words, and a FIFO control word and a FIFO status word. A write to the transmit window queues a byte. A read from the receive window dequeues one.

A separate serial engine, which is not part of this block, pulls bytes from the transmit FIFO and pushes received bytes into the receive FIFO. It reports the end of a transfer on a pulse input. The block turns that pulse, and any receive push it has to drop, into pending-event bits. Each event bit is cleared by writing one to it. The interrupt line is raised by any pending event whose enable is set.

The bus has no wait states. A read returns data in the cycle it is requested, from the state before that cycle's clock edge. A write, or the side effect of a read, takes effect at that edge.

Top module: `spim_csr_top`

## Requirements
- R1: After reset, every register reads 0: global control at 0x004, interrupt enable at 0x010, event status at 0x014, FIFO control at 0x018 and FIFO status at 0x01C. Both FIFOs are empty, and `irq_o`, `bus_en_o`, `master_o` and `xpause_o` are low.
- R2: Global control (0x004) bit 0 drives `bus_en_o`, bit 1 drives `master_o` and bit 7 drives `xpause_o`. These bits read back as written. Every other bit reads 0.
- R3: Writing global control with bit 31 set takes effect at that clock edge. It returns global control, interrupt enable and event status to 0 and empties both FIFOs. Bit 31 reads back as 0.
- R4: Each write to 0x200 queues `reg_wdata_i[7:0]`. `tx_data_o` shows the oldest queued byte, and `tx_pop_i` removes it. The transmit count appears in FIFO status bits 23:16.
- R5: The transmit FIFO holds `FIFO_DEPTH` (128) bytes. A write to 0x200 while it is full is dropped, and the count stays at 128. A pop while it is empty has no effect.
- R6: `rx_push_i` queues `rx_data_i`. A read of 0x300 returns the oldest received byte in bits 7:0 and removes it. The receive count appears in FIFO status bits 7:0. A read of 0x300 while the FIFO is empty returns 0 and leaves the count at 0.
- R7: A receive push while the receive FIFO holds 128 bytes is dropped and sets event status bit 8. The bytes already held are unchanged.
- R8: A cycle with `evt_done_i` high sets event status bit 12 at the next clock edge.
- R9: Writing 1 to an event status bit clears it, and writing 0 leaves it alone. When a clear and a new event for the same bit fall in the same cycle, the bit stays set.
- R10: Interrupt enable (0x010) keeps bits 8 and 12, and every other bit reads 0. `irq_o` is high whenever a status bit and its enable bit are both set. It follows a change in either with one clock edge of latency.
- R11: Writing FIFO control (0x018) with bit 15 set empties the receive FIFO, and with bit 31 set empties the transmit FIFO. Each bit acts only on its own FIFO, and both read back as 0.
- R12: Reads of any offset not listed above return 0, and writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access in this cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the requesting cycle |
| tx_pop_i | input | 1 | Engine takes the oldest transmit byte |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| rx_push_i | input | 1 | Engine delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_full_o | output | 1 | Receive FIFO full |
| evt_done_i | input | 1 | Transfer-complete pulse |
| bus_en_o | output | 1 | Bus enable control bit |
| master_o | output | 1 | Master mode control bit |
| xpause_o | output | 1 | Transmit-pause enable control bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench fills the transmit FIFO past 128 entries and then drains it. An off-by-one in the full test would either keep a 129th byte or wrap the write pointer over the oldest entry, which shows up as a wrong count or a wrong byte order. It overruns the receive FIFO and checks three things: the overflow bit is set, the count stops at 128, and the first byte read back is still the first byte pushed. A design that overwrote on overflow would fail that last check.

The write-one-to-clear tests use partial masks and also put a clear and a new event in the same cycle. A design that cleared the whole word, or let the clear win, would lose the pending event. Soft reset and the two per-FIFO reset bits are each applied with other state loaded. A design that missed one register, or emptied the wrong FIFO, would leave visible state behind.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned REG_W  = 32;

  localparam logic [ADDR_W-1:0] OFF_GCTL  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_ISTA  = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_FCTL  = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_FSTA  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFF_TXWIN = 12'h200;
  localparam logic [ADDR_W-1:0] OFF_RXWIN = 12'h300;

  localparam int unsigned GB_EN     = 0;
  localparam int unsigned GB_MST    = 1;
  localparam int unsigned GB_PAUSE  = 7;
  localparam int unsigned GB_SRST   = 31;
  localparam int unsigned IB_OVF    = 8;
  localparam int unsigned IB_DONE   = 12;
  localparam int unsigned FB_RXRST  = 15;
  localparam int unsigned FB_TXRST  = 31;
  localparam int unsigned FS_RX_LSB = 0;
  localparam int unsigned FS_TX_LSB = 16;

  localparam int unsigned N_EVT   = 2;
  localparam int unsigned EVT_OVF = 0;
  localparam int unsigned EVT_DONE = 1;

  typedef struct packed {
    logic pause;
    logic mst;
    logic en;
  } gctl_t;
endpackage

// File: rtl/spim_byte_fifo.sv
`timescale 1ns/1ps
module spim_byte_fifo #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [DW-1:0]    data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    data_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             drop_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_FULL);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  // full is judged before the edge: a pop in the same cycle does not make room
  assign drop_o  = push_i && full_o && !flush_i;
  assign data_o  = mem_q[rptr_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wptr_q] <= data_i;
  end
endmodule

// File: rtl/spim_irq_ctrl.sv
`timescale 1ns/1ps
module spim_irq_ctrl #(
  parameter int unsigned N_EVT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_all_i,
  input  logic [N_EVT-1:0] set_i,
  input  logic [N_EVT-1:0] w1c_i,
  input  logic             ien_we_i,
  input  logic [N_EVT-1:0] ien_d_i,
  output logic [N_EVT-1:0] sta_o,
  output logic [N_EVT-1:0] ien_o,
  output logic             irq_o
);
  logic [N_EVT-1:0] sta_q, ien_q;

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    // new event beats a same-cycle clear; soft reset beats both
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           sta_q[i] <= 1'b0;
      else if (clr_all_i)    sta_q[i] <= 1'b0;
      else if (set_i[i])     sta_q[i] <= 1'b1;
      else if (w1c_i[i])     sta_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ien_q <= '0;
    else if (clr_all_i) ien_q <= '0;
    else if (ien_we_i)  ien_q <= ien_d_i;
  end

  assign sta_o = sta_q;
  assign ien_o = ien_q;
  assign irq_o = |(sta_q & ien_q);
endmodule

// File: rtl/spim_csr_top.sv
`timescale 1ns/1ps
module spim_csr_top
  import spim_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 128,
  parameter int unsigned DW         = 8,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              tx_pop_i,
  output logic [DW-1:0]     tx_data_o,
  output logic              tx_empty_o,
  input  logic              rx_push_i,
  input  logic [DW-1:0]     rx_data_i,
  output logic              rx_full_o,
  input  logic              evt_done_i,
  output logic              bus_en_o,
  output logic              master_o,
  output logic              xpause_o,
  output logic              irq_o
);
  logic wr, rd, soft_rst, tx_flush, rx_flush, tx_push, rx_pop;
  logic tx_full, rx_empty, rx_drop, tx_drop;
  logic [DW-1:0]    rx_head;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [N_EVT-1:0] sta, ien, evt_set, evt_w1c, ien_d;
  gctl_t gctl_q;

  assign wr       = reg_req_i && reg_we_i;
  assign rd       = reg_req_i && !reg_we_i;
  assign soft_rst = wr && (reg_addr_i == OFF_GCTL) && reg_wdata_i[GB_SRST];
  assign tx_flush = soft_rst || (wr && (reg_addr_i == OFF_FCTL) && reg_wdata_i[FB_TXRST]);
  assign rx_flush = soft_rst || (wr && (reg_addr_i == OFF_FCTL) && reg_wdata_i[FB_RXRST]);
  assign tx_push  = wr && (reg_addr_i == OFF_TXWIN);
  assign rx_pop   = rd && (reg_addr_i == OFF_RXWIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gctl_q <= '0;
    else if (soft_rst) gctl_q <= '0;
    else if (wr && reg_addr_i == OFF_GCTL) begin
      gctl_q.en    <= reg_wdata_i[GB_EN];
      gctl_q.mst   <= reg_wdata_i[GB_MST];
      gctl_q.pause <= reg_wdata_i[GB_PAUSE];
    end
  end

  assign bus_en_o = gctl_q.en;
  assign master_o = gctl_q.mst;
  assign xpause_o = gctl_q.pause;

  spim_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i(tx_flush), .push_i(tx_push), .data_i(reg_wdata_i[DW-1:0]),
    .pop_i(tx_pop_i), .data_o(tx_data_o), .cnt_o(tx_cnt),
    .full_o(tx_full), .empty_o(tx_empty_o), .drop_o(tx_drop)
  );

  spim_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i(rx_flush), .push_i(rx_push_i), .data_i(rx_data_i),
    .pop_i(rx_pop), .data_o(rx_head), .cnt_o(rx_cnt),
    .full_o(rx_full_o), .empty_o(rx_empty), .drop_o(rx_drop)
  );

  always_comb begin
    evt_set           = '0;
    evt_set[EVT_OVF]  = rx_drop;
    evt_set[EVT_DONE] = evt_done_i;
    evt_w1c           = '0;
    ien_d             = '0;
    ien_d[EVT_OVF]    = reg_wdata_i[IB_OVF];
    ien_d[EVT_DONE]   = reg_wdata_i[IB_DONE];
    if (wr && reg_addr_i == OFF_ISTA) begin
      evt_w1c[EVT_OVF]  = reg_wdata_i[IB_OVF];
      evt_w1c[EVT_DONE] = reg_wdata_i[IB_DONE];
    end
  end

  spim_irq_ctrl #(.N_EVT(N_EVT)) u_irq (
    .clk_i, .rst_ni,
    .clr_all_i(soft_rst), .set_i(evt_set), .w1c_i(evt_w1c),
    .ien_we_i(wr && reg_addr_i == OFF_IEN), .ien_d_i(ien_d),
    .sta_o(sta), .ien_o(ien), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (rd) begin
      unique case (reg_addr_i)
        OFF_GCTL: begin
          reg_rdata_o[GB_EN]    = gctl_q.en;
          reg_rdata_o[GB_MST]   = gctl_q.mst;
          reg_rdata_o[GB_PAUSE] = gctl_q.pause;
        end
        OFF_IEN: begin
          reg_rdata_o[IB_OVF]  = ien[EVT_OVF];
          reg_rdata_o[IB_DONE] = ien[EVT_DONE];
        end
        OFF_ISTA: begin
          reg_rdata_o[IB_OVF]  = sta[EVT_OVF];
          reg_rdata_o[IB_DONE] = sta[EVT_DONE];
        end
        OFF_FSTA: begin
          reg_rdata_o[FS_RX_LSB +: CNT_W] = rx_cnt;
          reg_rdata_o[FS_TX_LSB +: CNT_W] = tx_cnt;
        end
        OFF_RXWIN: reg_rdata_o[DW-1:0] = rx_empty ? '0 : rx_head;
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^{tx_full, tx_drop};
endmodule

// File: rtl/spim_csr_checker.sv
`timescale 1ns/1ps
module spim_csr_checker
  import spim_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic              tx_pop_i,
  input logic              rx_push_i,
  input logic              evt_done_i,
  input logic              bus_en_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  tx_cnt_i,
  input logic [CNT_W-1:0]  rx_cnt_i,
  input logic [N_EVT-1:0]  sta_i,
  input logic [N_EVT-1:0]  ien_i
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  logic wr, srst, rxr, txr, rxrd;
  assign wr   = reg_req_i && reg_we_i;
  assign srst = wr && reg_addr_i == OFF_GCTL && reg_wdata_i[GB_SRST];
  assign rxr  = srst || (wr && reg_addr_i == OFF_FCTL && reg_wdata_i[FB_RXRST]);
  assign txr  = srst || (wr && reg_addr_i == OFF_FCTL && reg_wdata_i[FB_TXRST]);
  assign rxrd = reg_req_i && !reg_we_i && reg_addr_i == OFF_RXWIN;

  assert_soft_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (tx_cnt_i == '0 && rx_cnt_i == '0 && !bus_en_o && sta_i == '0 && ien_i == '0));

  assert_tx_full_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_addr_i == OFF_TXWIN && tx_cnt_i == FULL && !tx_pop_i && !txr) |=> tx_cnt_i == FULL);

  assert_rx_empty_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxrd && rx_cnt_i == '0 && !rx_push_i) |=> rx_cnt_i == '0);

  assert_overflow_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_cnt_i == FULL && !rxr) |=> sta_i[EVT_OVF]);

  assert_done_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_done_i && !srst) |=> sta_i[EVT_DONE]);

  assert_irq_raise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_done_i && !srst && ien_i[EVT_DONE] && !(wr && reg_addr_i == OFF_IEN)) |=> irq_o);

  assert_rx_flush_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxr |=> rx_cnt_i == '0);

  assert_tx_flush_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txr |=> tx_cnt_i == '0);
endmodule

bind spim_csr_top spim_csr_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_req_i(reg_req_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .tx_pop_i(tx_pop_i),
  .rx_push_i(rx_push_i), .evt_done_i(evt_done_i), .bus_en_o(bus_en_o), .irq_o(irq_o),
  .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .sta_i(sta), .ien_i(ien)
);

// File: tb/tb_spim_csr_top.sv
`timescale 1ns/1ps
module tb_spim_csr_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0, tx_pop = 0, rx_push = 0, done_evt = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  tx_data, rx_data = '0;
  logic        tx_empty, rx_full, bus_en, mst, xpause, irq;
  int n_cmp = 0, n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spim_csr_top dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tx_pop_i(tx_pop), .tx_data_o(tx_data),
    .tx_empty_o(tx_empty), .rx_push_i(rx_push), .rx_data_i(rx_data), .rx_full_o(rx_full),
    .evt_done_i(done_evt), .bus_en_o(bus_en), .master_o(mst), .xpause_o(xpause), .irq_o(irq)
  );

  task automatic chk(input string req_id, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req_id, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_data = b;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done_evt = 1;
    @(negedge clk); done_evt = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h004, v); chk("R1 gctl", v, 0);
    rd(12'h010, v); chk("R1 ien", v, 0);
    rd(12'h014, v); chk("R1 ista", v, 0);
    rd(12'h018, v); chk("R1 fctl", v, 0);
    rd(12'h01C, v); chk("R1 fsta", v, 0);
    chk("R1 outs", {28'd0, irq, bus_en, mst, xpause}, 0);
  endtask

  task automatic t_gctl();
    logic [31:0] v;
    wr(12'h004, 32'h7FFF_FFFF);
    rd(12'h004, v); chk("R2 gctl readback", v, 32'h83);
    chk("R2 outputs", {29'd0, bus_en, mst, xpause}, 3'b111);
    wr(12'h004, 32'h0000_0002);
    chk("R2 outputs partial", {29'd0, bus_en, mst, xpause}, 3'b010);
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h008, v); chk("R12 unmapped read", v, 0);
    rd(12'h004, v); chk("R12 no side effect", v, 32'h2);
    rd(12'h01C, v); chk("R12 fifos untouched", v, 0);
  endtask

  task automatic t_tx_basic();
    logic [31:0] v;
    wr(12'h200, 32'hA1); wr(12'h200, 32'hB2); wr(12'h200, 32'hC3);
    rd(12'h01C, v); chk("R4 tx count", v, 32'h0003_0000);
    chk("R4 tx head", tx_data, 8'hA1);
    pop_tx();
    chk("R4 tx order", tx_data, 8'hB2);
    rd(12'h01C, v); chk("R4 tx count after pop", v, 32'h0002_0000);
  endtask

  task automatic t_tx_full();
    logic [31:0] v;
    wr(12'h018, 32'h8000_0000);
    for (int i = 0; i < 130; i++) wr(12'h200, 32'h10 + i);
    rd(12'h01C, v); chk("R5 tx count capped", v, 32'h0080_0000);
    for (int i = 0; i < 128; i++) begin
      chk("R5 tx drain order", tx_data, 8'(8'h10 + i));
      pop_tx();
    end
    chk("R5 tx empty", tx_empty, 1);
    pop_tx();
    rd(12'h01C, v); chk("R5 pop on empty", v, 0);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    push_rx(8'h5A); push_rx(8'h6B); push_rx(8'h7C);
    rd(12'h01C, v); chk("R6 rx count", v, 3);
    rd(12'h300, v); chk("R6 rx byte0", v, 32'h5A);
    rd(12'h300, v); chk("R6 rx byte1", v, 32'h6B);
    rd(12'h300, v); chk("R6 rx byte2", v, 32'h7C);
    rd(12'h300, v); chk("R6 rx empty read", v, 0);
    rd(12'h01C, v); chk("R6 rx count empty", v, 0);
  endtask

  task automatic t_rx_ovf();
    logic [31:0] v;
    for (int i = 0; i < 128; i++) push_rx(8'(i + 1));
    chk("R7 rx full", rx_full, 1);
    rd(12'h014, v); chk("R7 no flag yet", v, 0);
    push_rx(8'hEE);
    rd(12'h014, v); chk("R7 overflow flag", v, 32'h100);
    rd(12'h01C, v); chk("R7 count capped", v, 32'h80);
    rd(12'h300, v); chk("R7 oldest kept", v, 32'h01);
    wr(12'h018, 32'h0000_8000);
  endtask

  task automatic t_events();
    logic [31:0] v;
    wr(12'h014, 32'hFFFF_FFFF);
    rd(12'h014, v); chk("R9 clear all", v, 0);
    pulse_done();
    rd(12'h014, v); chk("R8 done flag", v, 32'h1000);
    wr(12'h018, 32'h0000_8000);
    for (int i = 0; i < 129; i++) push_rx(8'h00);
    rd(12'h014, v); chk("R9 both pending", v, 32'h1100);
    wr(12'h014, 32'h0000_0100);
    rd(12'h014, v); chk("R9 partial clear", v, 32'h1000);
    @(negedge clk); req = 1; we = 1; addr = 12'h014; wdata = 32'h1000; done_evt = 1;
    @(negedge clk); req = 0; we = 0; done_evt = 0;
    rd(12'h014, v); chk("R9 event beats clear", v, 32'h1000);
    wr(12'h018, 32'h0000_8000);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    chk("R10 masked", irq, 0);
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, v); chk("R10 ien bits", v, 32'h1100);
    chk("R10 irq asserted", irq, 1);
    wr(12'h014, 32'h1000);
    chk("R10 irq after clear", irq, 0);
    @(negedge clk); done_evt = 1;
    @(negedge clk); done_evt = 0;
    chk("R10 irq one edge later", irq, 1);
    wr(12'h010, 32'h0000_0100);
    chk("R10 irq disabled", irq, 0);
    wr(12'h014, 32'hFFFF_FFFF);
  endtask

  task automatic t_fctl();
    logic [31:0] v;
    push_rx(8'h11); push_rx(8'h22);
    wr(12'h200, 32'h33); wr(12'h200, 32'h44);
    wr(12'h018, 32'h0000_8000);
    rd(12'h01C, v); chk("R11 rx only flushed", v, 32'h0002_0000);
    rd(12'h018, v); chk("R11 fctl reads 0", v, 0);
    push_rx(8'h55);
    wr(12'h018, 32'h8000_0000);
    rd(12'h01C, v); chk("R11 tx only flushed", v, 32'h0000_0001);
    rd(12'h300, v); chk("R11 rx after flush", v, 32'h55);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    wr(12'h004, 32'h83); wr(12'h010, 32'h1100);
    pulse_done(); push_rx(8'h9); wr(12'h200, 32'h7);
    chk("R3 irq before", irq, 1);
    wr(12'h004, 32'h8000_0083);
    rd(12'h004, v); chk("R3 gctl default", v, 0);
    rd(12'h010, v); chk("R3 ien default", v, 0);
    rd(12'h014, v); chk("R3 ista default", v, 0);
    rd(12'h01C, v); chk("R3 fifos empty", v, 0);
    chk("R3 outputs low", {28'd0, irq, bus_en, mst, xpause}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_gctl();
    t_tx_basic();
    t_tx_full();
    t_rx();
    t_rx_ovf();
    t_events();
    t_irq();
    t_fctl();
    t_srst();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule